// File: doc/BRIEF.md
# Alternating-Direction Crossbar Arbiter

This block is a single-level crossbar between a row of requestor ports and a set of memory ports. Each requestor presents one request beat (command, address, write data and a binary memory index) and holds it until accepted. Every memory port has its own arbiter, and that arbiter accepts at most one requestor per cycle. The accepted beat is registered onto the memory port together with the requestor's index. Read responses that come back from a memory port are steered to the requestor named in the returned tag.

The arbiter keeps no age and no rotating pointer. It holds a single direction bit for each memory port. When the bit is clear, the lowest-index contender wins. When it is set, the highest-index contender wins. The bit toggles on every cycle in which that memory port grants, and stays put on cycles with no grant. While the two outermost requestors keep requesting the same memory port, they take turns winning and the requestors between them never win. The block is meant to reproduce that starvation, not to prevent it.

To make the starvation measurable, each requestor port has a wait counter. It counts the cycles in which that port's request is stalled and stops at its maximum value.

Top module: `xbar_alt_arb`

## Requirements
- R1: After reset, every bit of mem_valid and rsp_valid is low, every wait counter reads zero, and every memory port starts in lowest-index-first direction.
- R2: req_target carries the binary index of the destination memory port. Arbitration for different memory ports is independent, so requestors aimed at different memory ports are accepted in the same cycle.
- R3: req_ready[i] rises combinationally in the same cycle only when req_valid[i] is high. Each memory port accepts at most one requestor per cycle. A beat is transferred on a rising edge where valid and ready are both high.
- R4: A memory port's first grant after reset goes to the lowest-index requestor aimed at it.
- R5: Each memory port alternates its direction on each cycle in which it grants, lowest-index-first then highest-index-first. A cycle with no contender leaves the direction unchanged.
- R6: In the cycle after a transfer, the memory port shows mem_valid high, the winner's write flag, address and write data, and mem_src equal to the winner's index. mem_valid is low after a cycle with no grant.
- R7: When mem_rsp_valid[m] is high with tag t, rsp_valid[t] is high in the next cycle with the data of memory port m, and all other rsp_valid bits are low. The environment returns at most one response per requestor per cycle.
- R8: A requestor's wait counter increments on each cycle in which req_valid is high and req_ready is low. It stops at 2^WAIT_W-1, clears to zero after a transfer, and holds its value while the port is idle.
- R9: If requestors 0 and N_REQ-1 re-request one memory port every cycle, a middle requestor aimed at the same memory port is never granted, and its wait counter saturates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | N_REQ | Request present, one bit per requestor |
| req_ready | output | N_REQ | Request accepted this cycle |
| req_target | input | N_REQ*MEM_W | Destination memory index per requestor |
| req_write | input | N_REQ | 1 = write, 0 = read |
| req_addr | input | N_REQ*AW | Address per requestor |
| req_wdata | input | N_REQ*DW | Write data per requestor |
| mem_valid | output | N_MEM | Beat issued on memory port |
| mem_write | output | N_MEM | Write flag of issued beat |
| mem_addr | output | N_MEM*AW | Address of issued beat |
| mem_wdata | output | N_MEM*DW | Write data of issued beat |
| mem_src | output | N_MEM*SRC_W | Index of requestor that issued the beat |
| mem_rsp_valid | input | N_MEM | Read response from memory port |
| mem_rsp_tag | input | N_MEM*SRC_W | Requestor index of the response |
| mem_rsp_data | input | N_MEM*DW | Read data |
| rsp_valid | output | N_REQ | Response delivered to requestor |
| rsp_data | output | N_REQ*DW | Response data per requestor |
| wait_cnt | output | N_REQ*WAIT_W | Saturating stall counter per requestor |

## Verification
req_ready is combinational, so the bench drives requests at the falling edge and compares ready one time unit later, inside the same cycle. The memory-port beat, the wait counters and delivered responses each sit behind one register. The bench therefore computes their expected values at the grant (or at the response it drives) and compares them at the next falling edge. The bench memory answers each read in the same cycle it appears on the memory port, so the data arrives at the requestor two cycles after the transfer.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    typedef enum logic {
        PICK_LOW  = 1'b0,
        PICK_HIGH = 1'b1
    } pick_dir_e;
endpackage

// File: rtl/alt_pick.sv
module alt_pick
    import xbar_pkg::*;
#(
    parameter int N_REQ = 16,
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int SRC_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_REQ-1:0]           hit,
    input  logic [N_REQ-1:0]           req_write,
    input  logic [N_REQ-1:0][AW-1:0]   req_addr,
    input  logic [N_REQ-1:0][DW-1:0]   req_wdata,
    output logic [N_REQ-1:0]           gnt,
    output logic                       mem_valid,
    output logic                       mem_write,
    output logic [AW-1:0]              mem_addr,
    output logic [DW-1:0]              mem_wdata,
    output logic [SRC_W-1:0]           mem_src
);
    typedef struct packed {
        pick_dir_e          dir;
        logic               vld;
        logic               wr;
        logic [AW-1:0]      addr;
        logic [DW-1:0]      wdata;
        logic [SRC_W-1:0]   src;
    } pick_st_t;

    pick_st_t st_d, st_q;
    logic [SRC_W-1:0] lo_idx, hi_idx, win_idx;
    logic             any_hit;

    always_comb begin
        lo_idx = '0;
        hi_idx = '0;
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (hit[i]) lo_idx = SRC_W'(i);
        end
        for (int i = 0; i < N_REQ; i++) begin
            if (hit[i]) hi_idx = SRC_W'(i);
        end
        any_hit = |hit;
        win_idx = (st_q.dir == PICK_LOW) ? lo_idx : hi_idx;
        gnt     = '0;
        if (any_hit) gnt[win_idx] = 1'b1;

        st_d       = st_q;
        st_d.vld   = any_hit;
        if (any_hit) begin
            st_d.dir   = (st_q.dir == PICK_LOW) ? PICK_HIGH : PICK_LOW;
            st_d.wr    = req_write[win_idx];
            st_d.addr  = req_addr[win_idx];
            st_d.wdata = req_wdata[win_idx];
            st_d.src   = win_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{dir: PICK_LOW, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_valid = st_q.vld;
    assign mem_write = st_q.wr;
    assign mem_addr  = st_q.addr;
    assign mem_wdata = st_q.wdata;
    assign mem_src   = st_q.src;

    p_one_gnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    p_gnt_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~hit) == '0);
    p_low_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dir == PICK_LOW && gnt != '0) |-> ((hit & (gnt - N_REQ'(1))) == '0));
    p_high_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dir == PICK_HIGH && gnt != '0) |-> ((hit & ~(gnt | (gnt - N_REQ'(1)))) == '0));
    p_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0) |=> (st_q.dir != $past(st_q.dir)));
    p_idle_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |=> $stable(st_q.dir));
    p_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0) |=> mem_valid);
    p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0) |=> !mem_valid);
endmodule

// File: rtl/wait_meter.sv
module wait_meter #(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              ready,
    output logic [WAIT_W-1:0] cnt
);
    localparam logic [WAIT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [WAIT_W-1:0] cnt;
    } meter_st_t;

    meter_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (valid && ready) begin
            st_d.cnt = '0;
        end else if (valid && st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + WAIT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    p_wait_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready) |=> (cnt == '0));
    p_wait_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready && cnt == CNT_MAX) |=> (cnt == CNT_MAX));
    p_wait_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready && cnt != CNT_MAX) |=> (cnt == $past(cnt) + WAIT_W'(1)));
    p_wait_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(cnt));
endmodule

// File: rtl/rsp_route.sv
module rsp_route #(
    parameter int N_REQ = 16,
    parameter int N_MEM = 8,
    parameter int DW    = 32,
    parameter int SRC_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_MEM-1:0]             mem_rsp_valid,
    input  logic [N_MEM-1:0][SRC_W-1:0]  mem_rsp_tag,
    input  logic [N_MEM-1:0][DW-1:0]     mem_rsp_data,
    output logic [N_REQ-1:0]             rsp_valid,
    output logic [N_REQ-1:0][DW-1:0]     rsp_data
);
    typedef struct packed {
        logic [N_REQ-1:0]          vld;
        logic [N_REQ-1:0][DW-1:0]  data;
    } route_st_t;

    route_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = '0;
        for (int r = 0; r < N_REQ; r++) begin
            for (int m = 0; m < N_MEM; m++) begin
                if (mem_rsp_valid[m] && mem_rsp_tag[m] == SRC_W'(r)) begin
                    st_d.vld[r]  = 1'b1;
                    st_d.data[r] = mem_rsp_data[m];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.vld;
    assign rsp_data  = st_q.data;

    for (genvar r = 0; r < N_REQ; r++) begin : g_col
        logic [N_MEM-1:0] col;
        for (genvar m = 0; m < N_MEM; m++) begin : g_bit
            assign col[m] = mem_rsp_valid[m] && (mem_rsp_tag[m] == SRC_W'(r));
        end
        p_rsp_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(col) <= 1);
    end

    for (genvar m = 0; m < N_MEM; m++) begin : g_deliver
        p_rsp_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
            mem_rsp_valid[m] |=> rsp_valid[$past(mem_rsp_tag[m])]);
    end
endmodule

// File: rtl/xbar_alt_arb.sv
module xbar_alt_arb #(
    parameter int N_REQ  = 16,
    parameter int N_MEM  = 8,
    parameter int AW     = 16,
    parameter int DW     = 32,
    parameter int WAIT_W = 8,
    localparam int MEM_W = (N_MEM > 1) ? $clog2(N_MEM) : 1,
    localparam int SRC_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_REQ-1:0]          req_valid,
    output logic [N_REQ-1:0]          req_ready,
    input  logic [N_REQ*MEM_W-1:0]    req_target,
    input  logic [N_REQ-1:0]          req_write,
    input  logic [N_REQ*AW-1:0]       req_addr,
    input  logic [N_REQ*DW-1:0]       req_wdata,
    output logic [N_MEM-1:0]          mem_valid,
    output logic [N_MEM-1:0]          mem_write,
    output logic [N_MEM*AW-1:0]       mem_addr,
    output logic [N_MEM*DW-1:0]       mem_wdata,
    output logic [N_MEM*SRC_W-1:0]    mem_src,
    input  logic [N_MEM-1:0]          mem_rsp_valid,
    input  logic [N_MEM*SRC_W-1:0]    mem_rsp_tag,
    input  logic [N_MEM*DW-1:0]       mem_rsp_data,
    output logic [N_REQ-1:0]          rsp_valid,
    output logic [N_REQ*DW-1:0]       rsp_data,
    output logic [N_REQ*WAIT_W-1:0]   wait_cnt
);
    logic [N_REQ-1:0][MEM_W-1:0]  tgt;
    logic [N_REQ-1:0][AW-1:0]     addr_a;
    logic [N_REQ-1:0][DW-1:0]     wdata_a;
    logic [N_MEM-1:0][N_REQ-1:0]  hit;
    logic [N_MEM-1:0][N_REQ-1:0]  gnt;
    logic [N_MEM-1:0][SRC_W-1:0]  rtag_a;
    logic [N_MEM-1:0][DW-1:0]     rdata_a;
    logic [N_REQ-1:0][DW-1:0]     rsp_a;

    for (genvar r = 0; r < N_REQ; r++) begin : g_req
        assign tgt[r]     = req_target[r*MEM_W +: MEM_W];
        assign addr_a[r]  = req_addr[r*AW +: AW];
        assign wdata_a[r] = req_wdata[r*DW +: DW];
        assign rsp_data[r*DW +: DW] = rsp_a[r];

        wait_meter #(.WAIT_W(WAIT_W)) u_meter (
            .clk   (clk),
            .rst_n (rst_n),
            .valid (req_valid[r]),
            .ready (req_ready[r]),
            .cnt   (wait_cnt[r*WAIT_W +: WAIT_W])
        );

        p_ready_needs_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
            req_ready[r] |-> req_valid[r]);
    end

    for (genvar m = 0; m < N_MEM; m++) begin : g_mem
        for (genvar r = 0; r < N_REQ; r++) begin : g_hit
            assign hit[m][r] = req_valid[r] && (tgt[r] == MEM_W'(m));
        end
        assign rtag_a[m]  = mem_rsp_tag[m*SRC_W +: SRC_W];
        assign rdata_a[m] = mem_rsp_data[m*DW +: DW];

        alt_pick #(
            .N_REQ (N_REQ),
            .AW    (AW),
            .DW    (DW),
            .SRC_W (SRC_W)
        ) u_pick (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit       (hit[m]),
            .req_write (req_write),
            .req_addr  (addr_a),
            .req_wdata (wdata_a),
            .gnt       (gnt[m]),
            .mem_valid (mem_valid[m]),
            .mem_write (mem_write[m]),
            .mem_addr  (mem_addr[m*AW +: AW]),
            .mem_wdata (mem_wdata[m*DW +: DW]),
            .mem_src   (mem_src[m*SRC_W +: SRC_W])
        );
    end

    always_comb begin
        req_ready = '0;
        for (int m = 0; m < N_MEM; m++) begin
            req_ready = req_ready | gnt[m];
        end
    end

    rsp_route #(
        .N_REQ (N_REQ),
        .N_MEM (N_MEM),
        .DW    (DW),
        .SRC_W (SRC_W)
    ) u_route (
        .clk           (clk),
        .rst_n         (rst_n),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_tag   (rtag_a),
        .mem_rsp_data  (rdata_a),
        .rsp_valid     (rsp_valid),
        .rsp_data      (rsp_a)
    );
endmodule

// File: tb/sim_xbar_alt_arb.sv
`timescale 1ns/1ps
module sim_xbar_alt_arb;
    localparam int NR = 16;
    localparam int NM = 8;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int WW = 8;
    localparam int MW = 3;
    localparam int SW = 4;
    localparam int WMAX = (1 << WW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NR-1:0]    req_valid = '0;
    logic [NR-1:0]    req_ready;
    logic [NR*MW-1:0] req_target = '0;
    logic [NR-1:0]    req_write = '0;
    logic [NR*AW-1:0] req_addr = '0;
    logic [NR*DW-1:0] req_wdata = '0;
    logic [NM-1:0]    mem_valid, mem_write;
    logic [NM*AW-1:0] mem_addr;
    logic [NM*DW-1:0] mem_wdata;
    logic [NM*SW-1:0] mem_src;
    logic [NM-1:0]    mem_rsp_valid = '0;
    logic [NM*SW-1:0] mem_rsp_tag = '0;
    logic [NM*DW-1:0] mem_rsp_data = '0;
    logic [NR-1:0]    rsp_valid;
    logic [NR*DW-1:0] rsp_data;
    logic [NR*WW-1:0] wait_cnt;

    always #2.5 clk = ~clk;

    xbar_alt_arb u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_target(req_target), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .mem_valid(mem_valid), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_src(mem_src),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .wait_cnt(wait_cnt)
    );

    int n_vec = 0;
    int n_bad = 0;

    // bench model
    bit          pend [NR];
    bit [MW-1:0] tgt  [NR];
    bit          wr   [NR];
    bit [AW-1:0] adr  [NR];
    bit [DW-1:0] wd   [NR];
    bit          mdir [NM];
    int          wexp [NR];
    int          seen [NR];
    bit          em_v [NM];
    bit          em_wr[NM];
    bit [AW-1:0] em_a [NM];
    bit [DW-1:0] em_d [NM];
    bit [SW-1:0] em_s [NM];
    bit          er_v [NR];
    bit [DW-1:0] er_d [NR];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ref_pick(input bit [NR-1:0] h, input bit dir);
        int w = -1;
        for (int i = 0; i < NR; i++) begin
            if (h[i]) begin
                if (dir) w = i;
                else if (w < 0) w = i;
            end
        end
        return w;
    endfunction

    function automatic bit [DW-1:0] rd_data(input bit [AW-1:0] a);
        return {a, ~a};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = '0;
        mem_rsp_valid = '0;
        for (int r = 0; r < NR; r++) begin
            pend[r] = 0; wexp[r] = 0; seen[r] = 0; er_v[r] = 0;
        end
        for (int m = 0; m < NM; m++) begin
            mdir[m] = 0; em_v[m] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(mem_valid == '0, "R1 mem_valid", longint'(mem_valid), 0);
        chk(rsp_valid == '0, "R1 rsp_valid", longint'(rsp_valid), 0);
        chk(wait_cnt == '0, "R1 wait_cnt", longint'(wait_cnt[63:0]), 0);
    endtask

    task automatic new_req(input int r, input int t);
        pend[r] = 1;
        tgt[r]  = MW'(t);
        wr[r]   = 1'($urandom % 2);
        adr[r]  = AW'($urandom);
        wd[r]   = DW'($urandom);
    endtask

    // mode 0 random, 1 starvation, 2 parallel targets, 3 sparse with idle gaps
    task automatic step(input int mode);
        bit [NR-1:0] exp_rdy;
        @(negedge clk);
        for (int r = 0; r < NR; r++) begin
            chk(rsp_valid[r] == er_v[r], "R7 rsp_valid", longint'(rsp_valid[r]), longint'(er_v[r]));
            if (er_v[r])
                chk(rsp_data[r*DW +: DW] == er_d[r], "R7 rsp_data",
                    longint'(rsp_data[r*DW +: DW]), longint'(er_d[r]));
            chk(int'(wait_cnt[r*WW +: WW]) == wexp[r], "R8 wait_cnt",
                longint'(wait_cnt[r*WW +: WW]), longint'(wexp[r]));
        end
        for (int m = 0; m < NM; m++) begin
            chk(mem_valid[m] == em_v[m], "R6 mem_valid", longint'(mem_valid[m]), longint'(em_v[m]));
            if (em_v[m]) begin
                chk(mem_write[m] == em_wr[m] && mem_addr[m*AW +: AW] == em_a[m] &&
                    mem_src[m*SW +: SW] == em_s[m] &&
                    (!em_wr[m] || mem_wdata[m*DW +: DW] == em_d[m]),
                    "R6 mem beat", longint'({mem_src[m*SW +: SW], mem_addr[m*AW +: AW]}),
                    longint'({em_s[m], em_a[m]}));
            end
        end
        // memory model answers reads in the cycle they appear
        for (int r = 0; r < NR; r++) er_v[r] = 0;
        for (int m = 0; m < NM; m++) begin
            mem_rsp_valid[m] = em_v[m] && !em_wr[m];
            mem_rsp_tag[m*SW +: SW] = em_s[m];
            mem_rsp_data[m*DW +: DW] = rd_data(em_a[m]);
            if (em_v[m] && !em_wr[m]) begin
                er_v[em_s[m]] = 1;
                er_d[em_s[m]] = rd_data(em_a[m]);
            end
        end
        // new requests for idle ports
        for (int r = 0; r < NR; r++) begin
            if (!pend[r]) begin
                case (mode)
                    0: if ($urandom % 3 == 0) new_req(r, int'($urandom % NM));
                    1: if (r == 0 || r == 7 || r == NR - 1) new_req(r, 3);
                    2: new_req(r, r % NM);
                    default: if ((r == 5 || r == 9) && ($urandom % 4 == 0)) new_req(r, 1);
                endcase
            end
        end
        for (int r = 0; r < NR; r++) begin
            req_valid[r] = pend[r];
            req_target[r*MW +: MW] = tgt[r];
            req_write[r] = wr[r];
            req_addr[r*AW +: AW] = adr[r];
            req_wdata[r*DW +: DW] = wd[r];
        end
        #1;
        exp_rdy = '0;
        for (int m = 0; m < NM; m++) begin
            bit [NR-1:0] h = '0;
            int w;
            for (int r = 0; r < NR; r++) h[r] = pend[r] && (int'(tgt[r]) == m);
            w = ref_pick(h, mdir[m]);
            em_v[m] = (w >= 0);
            if (w >= 0) begin
                exp_rdy[w] = 1;
                em_wr[m] = wr[w]; em_a[m] = adr[w]; em_d[m] = wd[w]; em_s[m] = SW'(w);
                mdir[m] = !mdir[m];
                seen[w]++;
            end
        end
        // R2 R3 R4 R5: grant vector across all memory ports
        chk(req_ready == exp_rdy, "R3/R4/R5 req_ready", longint'(req_ready), longint'(exp_rdy));
        for (int r = 0; r < NR; r++) begin
            if (pend[r] && exp_rdy[r]) begin
                wexp[r] = 0;
                pend[r] = 0;
            end else if (pend[r] && wexp[r] < WMAX) begin
                wexp[r]++;
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // R4 R5 directed: two contenders on one port, then idle gap
        do_reset();
        new_req(3, 2); new_req(11, 2);
        step(3);   // R4 first grant goes to 3
        step(3);   // 11 next, then idle cycles keep direction (R5)
        repeat (4) step(3);
        // random traffic
        do_reset();
        repeat (2000) step(0);
        // R2 parallel targets
        do_reset();
        repeat (40) step(2);
        // R5 sparse with idle gaps
        do_reset();
        repeat (300) step(3);
        // R9 starvation of a middle port
        do_reset();
        repeat (400) step(1);
        chk(seen[7] == 0, "R9 middle port granted", longint'(seen[7]), 0);
        chk(seen[0] > 100 && seen[NR-1] > 100, "R9 edge ports served",
            longint'(seen[0]), longint'(seen[NR-1]));
        chk(int'(wait_cnt[7*WW +: WW]) == WMAX, "R8 R9 saturation",
            longint'(wait_cnt[7*WW +: WW]), longint'(WMAX));
        step(3);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule